// File: doc/BRIEF.md
# Prescaled 8-bit timer/counter

This block is an up-counter with a width of one byte. It takes one of two count sources. The first is a one-cycle strobe that marks each instruction cycle. The second is an external input pin, counted on a rising or a falling transition. A programmable power-of-two divider can sit between the chosen source and the counter. Three registers sit on a small synchronous register bus: the count, a control word and an overflow status word.

When the counter wraps from its highest value back to zero, it sets a sticky overflow flag. This flag drives an interrupt line through an enable bit, and software clears it. A write to the count register restarts the divider. It also holds the counter still for the next two instruction-cycle strobes, so a value written by software is not advanced straight away.

Top module: `tmr8_unit`

## Requirements
- R1: After reset the count, the control word, the overflow flag, the interrupt enable and `irq` are all zero.
- R2: A bus write to address 0 loads the count, and a read of address 0 returns the current count.
- R3: With control bit 5 (source) clear and control bit 3 (divider on) clear, the count goes up by exactly one on each cycle where `cyc_tick` is high. It does not change on cycles where `cyc_tick` is low.
- R4: With control bit 5 set, the count advances on transitions of `ext_pin`. Control bit 4 picks the transition: clear counts low-to-high, set counts high-to-low. The pin passes through a two-flop synchronizer, and transitions are seen only on `cyc_tick` cycles.
- R5: With control bit 3 set, only one counted event in every 2^(PS+1) reaches the counter, where PS is control bits 2:0.
- R6: A write to the count register clears the divider. A full 2^(PS+1) events must then occur before the next increment.
- R7: After a count write, the next two `cyc_tick` cycles cause no increment. A `cyc_tick` in the same cycle as the write is also ignored.
- R8: An increment from FFh to 00h sets the overflow flag (address 2, bit 0), and the flag stays set.
- R9: Writing address 2 with bit 0 low clears the flag, and writing bit 0 high leaves the flag unchanged. An overflow in the same cycle as a clear leaves the flag set.
- R10: `irq` is high exactly when the overflow flag and the interrupt enable (address 2, bit 1) are both set.
- R11: Address 1 reads back the six control bits with the upper bits zero. Address 2 reads back {enable, flag} in bits 1:0. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_tick | input | 1 | One-cycle strobe per instruction cycle |
| ext_pin | input | 1 | External count input, asynchronous |
| bus_addr | input | 2 | Register address: 0 count, 1 control, 2 status |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Overflow interrupt |

## Verification
A wrong hold counter shows up in the count readback on the first strobe after a write: the count either moves one strobe early or stays still one strobe too long. A divider that was not cleared, or that has the wrong mask, produces an increment earlier or later than 2^(PS+1) events after the count write. A flag that is wrongly set or cleared shows at once on `irq` and at address 2. The random phase reads the registers after every stimulus cycle, so any difference from the model shows up within one cycle of the state going wrong.

// File: rtl/tmr8_pkg.sv
`timescale 1ns/1ps
package tmr8_pkg;
   typedef enum logic [1:0] {
      A_COUNT  = 2'd0,
      A_CTRL   = 2'd1,
      A_STATUS = 2'd2,
      A_SPARE  = 2'd3
   } tmr_addr_e;

   localparam int STAT_FLAG_BIT = 0;
   localparam int STAT_EN_BIT   = 1;
endpackage

// File: rtl/tmr8_sync_edge.sv
`timescale 1ns/1ps
module tmr8_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic tick,
   input  logic fall_sel,
   output logic edge_ev
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tmr8_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              prev_q;
   logic              settled;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[STAGES-2:0], pin};
   end

   assign settled = sync_q[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    prev_q <= 1'b0;
      else if (tick) prev_q <= settled;
   end

   always_comb begin
      if (fall_sel) edge_ev = tick && prev_q && !settled;
      else          edge_ev = tick && !prev_q && settled;
   end
endmodule

// File: rtl/tmr8_presc.sv
`timescale 1ns/1ps
module tmr8_presc #(
   parameter int PSW = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           ev_in,
   input  logic           ps_on,
   input  logic [PSW-1:0] ps_sel,
   output logic           ev_out
);
   localparam int PREW = 1 << PSW;

   generate
      if (PSW < 1 || PSW > 4) begin : g_bad_psw
         $error("tmr8_presc: PSW must be within 1..4");
      end
   endgenerate

   logic [PREW-1:0] cnt_q;
   logic [PREW-1:0] mask;
   logic            full;

   for (genvar i = 0; i < PREW; i++) begin : g_mask
      assign mask[i] = (ps_sel >= PSW'(i));
   end

   assign full = &(cnt_q | ~mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clr)            cnt_q <= '0;
      else if (ev_in && ps_on) cnt_q <= cnt_q + PREW'(1);
   end

   assign ev_out = ps_on ? (ev_in && full) : ev_in;
endmodule

// File: rtl/tmr8_count.sv
`timescale 1ns/1ps
module tmr8_count #(
   parameter int CW   = 8,
   parameter int HOLD = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          wr,
   input  logic [CW-1:0] wdata,
   input  logic          inc_ev,
   output logic [CW-1:0] count,
   output logic          hold_act,
   output logic          ovf
);
   localparam int HW = $clog2(HOLD + 1);

   generate
      if (HOLD < 1) begin : g_bad_hold
         $error("tmr8_count: HOLD must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [HW-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         hold_q <= '0;
      end else if (wr) begin
         cnt_q  <= wdata;
         hold_q <= HW'(HOLD);
      end else begin
         if (tick && (hold_q != '0)) hold_q <= hold_q - HW'(1);
         if (inc_ev)                 cnt_q  <= cnt_q + CW'(1);
      end
   end

   assign count    = cnt_q;
   assign hold_act = (hold_q != '0);
   assign ovf      = inc_ev && !wr && (&cnt_q);
endmodule

// File: rtl/tmr8_unit.sv
`timescale 1ns/1ps
module tmr8_unit #(
   parameter int CW     = 8,
   parameter int PSW    = 3,
   parameter int HOLD   = 2,
   parameter int STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cyc_tick,
   input  logic          ext_pin,
   input  logic [1:0]    bus_addr,
   input  logic          bus_wr,
   input  logic [CW-1:0] bus_wdata,
   output logic [CW-1:0] bus_rdata,
   output logic          irq
);
   import tmr8_pkg::*;

   localparam int CTLW     = PSW + 3;
   localparam int POS_PSON = PSW;
   localparam int POS_EDGE = PSW + 1;
   localparam int POS_SRC  = PSW + 2;

   generate
      if (CW < 2 || CW < CTLW) begin : g_bad_cw
         $error("tmr8_unit: CW too narrow for the control word");
      end
   endgenerate

   logic [CTLW-1:0] ctl_q;
   logic            ovf_flag_q;
   logic            irq_en_q;
   logic            wr_cnt, wr_ctl, wr_stat;
   logic            ext_ev, src_ev, gate_ev, inc_ev;
   logic [CW-1:0]   cnt_q;
   logic            hold_act, ovf;

   assign wr_cnt  = bus_wr && (bus_addr == A_COUNT);
   assign wr_ctl  = bus_wr && (bus_addr == A_CTRL);
   assign wr_stat = bus_wr && (bus_addr == A_STATUS);

   tmr8_sync_edge #(.STAGES(STAGES)) i_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (ext_pin),
      .tick     (cyc_tick),
      .fall_sel (ctl_q[POS_EDGE]),
      .edge_ev  (ext_ev)
   );

   assign src_ev  = ctl_q[POS_SRC] ? ext_ev : cyc_tick;
   assign gate_ev = src_ev && !hold_act && !wr_cnt;

   tmr8_presc #(.PSW(PSW)) i_presc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (wr_cnt),
      .ev_in  (gate_ev),
      .ps_on  (ctl_q[POS_PSON]),
      .ps_sel (ctl_q[PSW-1:0]),
      .ev_out (inc_ev)
   );

   tmr8_count #(.CW(CW), .HOLD(HOLD)) i_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (cyc_tick),
      .wr       (wr_cnt),
      .wdata    (bus_wdata),
      .inc_ev   (inc_ev),
      .count    (cnt_q),
      .hold_act (hold_act),
      .ovf      (ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (wr_ctl) ctl_q <= bus_wdata[CTLW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_flag_q <= 1'b0;
         irq_en_q   <= 1'b0;
      end else begin
         if (wr_stat) irq_en_q <= bus_wdata[STAT_EN_BIT];
         ovf_flag_q <= ovf || (ovf_flag_q && !(wr_stat && !bus_wdata[STAT_FLAG_BIT]));
      end
   end

   always_comb begin
      case (bus_addr)
         A_COUNT:  bus_rdata = cnt_q;
         A_CTRL:   bus_rdata = CW'(ctl_q);
         A_STATUS: bus_rdata = CW'({irq_en_q, ovf_flag_q});
         default:  bus_rdata = '0;
      endcase
   end

   assign irq = ovf_flag_q && irq_en_q;
endmodule

// File: rtl/tmr8_chk.sv
`timescale 1ns/1ps
module tmr8_chk #(
   parameter int CW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cyc_tick,
   input logic [1:0]    bus_addr,
   input logic          bus_wr,
   input logic [CW-1:0] bus_wdata,
   input logic [CW-1:0] count,
   input logic          flag,
   input logic          en,
   input logic          hold_act,
   input logic          irq
);
   logic wr0, clr_flag;
   assign wr0      = bus_wr && (bus_addr == 2'd0);
   assign clr_flag = bus_wr && (bus_addr == 2'd2) && !bus_wdata[0];

   AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      wr0 |=> (count == $past(bus_wdata))); // R2

   AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      (!cyc_tick && !wr0) |=> $stable(count)); // R3

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr0 |=> ((count == $past(count)) || (count == CW'($past(count) + CW'(1))))); // R3

   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_act && !wr0) |=> $stable(count)); // R7

   AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr0 && (&count)) |=> ((count != '0) || flag)); // R8

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr_flag) |=> flag); // R9

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag); // R10

   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !irq); // R10
endmodule

bind tmr8_unit tmr8_chk #(.CW(CW)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cyc_tick  (cyc_tick),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .count     (cnt_q),
   .flag      (ovf_flag_q),
   .en        (irq_en_q),
   .hold_act  (hold_act),
   .irq       (irq)
);

// File: tb/test_tmr8_unit.sv
`timescale 1ns/1ps
module test_tmr8_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       pin = 1'b0;
   logic [1:0] addr = 2'd0;
   logic       wr = 1'b0;
   logic [7:0] wd = 8'd0;
   logic [7:0] rdata;
   logic       irq;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   tmr8_unit i_tmr8_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .cyc_tick  (tick),
      .ext_pin   (pin),
      .bus_addr  (addr),
      .bus_wr    (wr),
      .bus_wdata (wd),
      .bus_rdata (rdata),
      .irq       (irq)
   );

   // reference model built from the requirements
   logic [7:0] m_cnt, m_pre, m_mask;
   logic [5:0] m_ctl;
   logic       m_flag, m_en, m_prev, m_s1, m_s2, m_ev, m_inc, m_ovf;
   int         m_hold;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_pre = 0; m_ctl = 0; m_flag = 0; m_en = 0;
         m_prev = 0; m_s1 = 0; m_s2 = 0; m_hold = 0;
      end else begin
         m_ev = 0; m_inc = 0; m_ovf = 0;
         if (tick) begin
            if (m_ctl[5]) m_ev = m_ctl[4] ? (m_prev && !m_s2) : (!m_prev && m_s2);
            else          m_ev = 1;
            m_prev = m_s2;
         end
         if (wr && addr == 2'd0) begin
            m_cnt = wd; m_pre = 0; m_hold = 2;
         end else begin
            if (tick && m_hold != 0) begin m_hold = m_hold - 1; m_ev = 0; end
            if (m_ev) begin
               if (m_ctl[3]) begin
                  m_mask = (8'd2 << m_ctl[2:0]) - 8'd1;
                  m_inc  = ((m_pre & m_mask) == m_mask);
                  m_pre  = m_pre + 8'd1;
               end else m_inc = 1;
               if (m_inc) begin
                  if (m_cnt == 8'hFF) m_ovf = 1;
                  m_cnt = m_cnt + 8'd1;
               end
            end
         end
         if (wr && addr == 2'd1) m_ctl = wd[5:0];
         if (wr && addr == 2'd2) begin m_en = wd[1]; if (!wd[0]) m_flag = 0; end
         if (m_ovf) m_flag = 1;
         m_s2 = m_s1; m_s1 = pin;
      end
   end

   function automatic logic [7:0] model_read(input logic [1:0] a);
      case (a)
         2'd0:    return m_cnt;
         2'd1:    return {2'b00, m_ctl};
         2'd2:    return {6'd0, m_en, m_flag};
         default: return 8'd0;
      endcase
   endfunction

   task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%02h exp=%02h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc(input logic t, input logic w, input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); tick = t; wr = w; addr = a; wd = d;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 2'd0, 8'd0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 2'd0, 8'd0);
   endtask

   task automatic expect_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk); tick = 0; wr = 0; addr = a; #1;
      check(rdata == exp, tag, rdata, exp);
   endtask

   task automatic expect_irq(input logic exp, input string tag);
      @(negedge clk); tick = 0; wr = 0; #1;
      check(irq == exp, tag, {7'd0, irq}, {7'd0, exp});
   endtask

   task automatic set_pin(input logic v);
      @(negedge clk); tick = 0; wr = 0; pin = v;
   endtask

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired act=00 exp=01");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] r;
      logic [1:0]  ra;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      expect_rd(2'd0, 8'h00, "R1");
      expect_rd(2'd1, 8'h00, "R1");
      expect_rd(2'd2, 8'h00, "R1");
      expect_irq(1'b0, "R1");

      // R2 load and read back; R7 hold after write
      cyc(1'b0, 1'b1, 2'd0, 8'h5A);
      expect_rd(2'd0, 8'h5A, "R2");
      ticks(2);
      expect_rd(2'd0, 8'h5A, "R7");
      ticks(1);
      expect_rd(2'd0, 8'h5B, "R7");
      // R3 no strobe, no change; then one per strobe
      idle(5);
      expect_rd(2'd0, 8'h5B, "R3");
      ticks(3);
      expect_rd(2'd0, 8'h5E, "R3");
      // R7 strobe in the write cycle is ignored
      cyc(1'b1, 1'b1, 2'd0, 8'h30);
      ticks(2);
      expect_rd(2'd0, 8'h30, "R7");
      ticks(1);
      expect_rd(2'd0, 8'h31, "R7");

      // R11 readback of control and status
      cyc(1'b0, 1'b1, 2'd1, 8'hFF);
      expect_rd(2'd1, 8'h3F, "R11");
      cyc(1'b0, 1'b1, 2'd1, 8'h00);
      expect_rd(2'd3, 8'h00, "R11");

      // R8 wrap sets flag; R10 irq follows flag and enable
      cyc(1'b0, 1'b1, 2'd2, 8'h02);
      expect_rd(2'd2, 8'h02, "R11");
      cyc(1'b0, 1'b1, 2'd0, 8'hFE);
      ticks(3);
      expect_rd(2'd0, 8'hFF, "R8");
      expect_rd(2'd2, 8'h02, "R8");
      ticks(1);
      expect_rd(2'd0, 8'h00, "R8");
      expect_rd(2'd2, 8'h03, "R8");
      expect_irq(1'b1, "R10");
      ticks(4);
      expect_rd(2'd2, 8'h03, "R8");
      // R9 writing bit0 high keeps flag, low clears it
      cyc(1'b0, 1'b1, 2'd2, 8'h03);
      expect_rd(2'd2, 8'h03, "R9");
      cyc(1'b0, 1'b1, 2'd2, 8'h00);
      expect_rd(2'd2, 8'h00, "R9");
      expect_irq(1'b0, "R10");
      // R9 overflow in the clear cycle wins; R10 enable off masks irq
      cyc(1'b0, 1'b1, 2'd0, 8'hFF);
      ticks(2);
      cyc(1'b1, 1'b1, 2'd2, 8'h00);
      expect_rd(2'd2, 8'h01, "R9");
      expect_irq(1'b0, "R10");
      cyc(1'b0, 1'b1, 2'd2, 8'h00);

      // R5 divide by four (PS=1, divider on)
      cyc(1'b0, 1'b1, 2'd1, 8'h09);
      cyc(1'b0, 1'b1, 2'd0, 8'h00);
      ticks(5);
      expect_rd(2'd0, 8'h00, "R5");
      ticks(1);
      expect_rd(2'd0, 8'h01, "R5");
      // R6 count write restarts the divider
      ticks(2);
      cyc(1'b0, 1'b1, 2'd0, 8'h40);
      ticks(5);
      expect_rd(2'd0, 8'h40, "R6");
      ticks(1);
      expect_rd(2'd0, 8'h41, "R6");

      // R4 external rising edges
      cyc(1'b0, 1'b1, 2'd1, 8'h20);
      cyc(1'b0, 1'b1, 2'd0, 8'h10);
      ticks(2);
      set_pin(1'b1); idle(3); ticks(1);
      expect_rd(2'd0, 8'h11, "R4");
      ticks(2);
      expect_rd(2'd0, 8'h11, "R4");
      set_pin(1'b0); idle(3); ticks(1);
      expect_rd(2'd0, 8'h11, "R4");
      // R4 falling edges
      cyc(1'b0, 1'b1, 2'd1, 8'h30);
      set_pin(1'b1); idle(3); ticks(1);
      expect_rd(2'd0, 8'h11, "R4");
      set_pin(1'b0); idle(3);
      expect_rd(2'd0, 8'h11, "R4");
      ticks(1);
      expect_rd(2'd0, 8'h12, "R4");

      // random phase against the model
      void'($urandom(32'd2024));
      for (int i = 0; i < 3000; i++) begin
         r = $urandom;
         @(negedge clk);
         tick = r[0];
         if (r[3:2] == 2'd0) pin = ~pin;
         wr   = (r[7:4] == 4'd0);
         addr = r[9:8];
         wd   = r[17:10];
         ra   = 2'(r[21:20] % 3);
         @(negedge clk); tick = 0; wr = 0; addr = ra; #1;
         check(rdata == model_read(ra), ra == 2'd0 ? "R3" : (ra == 2'd1 ? "R11" : "R8"),
               rdata, model_read(ra));
         check(irq == (m_flag && m_en), "R10", {7'd0, irq}, {7'd0, m_flag && m_en});
      end

      summary();
      $finish;
   end
endmodule